// File: doc/BRIEF.md
# Phase-Adjustable Demodulator Reference

This block produces the square-wave sign reference for a synchronous demodulator. A wavetable excitation generator marks the end of each excitation period with a pulse and advances on a slow step clock; the period is a fixed number of steps (200 by default). The block counts step clocks from that pulse, and when the count reaches an operator-chosen phase value it drives the reference high. A second counter then holds it high for exactly half a period. The result is a 50% duty-cycle square wave at the excitation frequency, lagging the table start by one step per phase count (1.8 degrees per count with the default period).

The step clock, the end-of-cycle marker and the external sync are treated as asynchronous levels. Each passes through a multi-flop synchronizer on the fast system clock, and the step clock and marker are then reduced to one-cycle edge pulses. A select bit can replace the generated wave with an externally supplied, synchronized reference, for example a signal from a mechanical light chopper. The phase value is captured only when an end-of-cycle marker arrives, so a value changed in mid-period never produces a partial period.

Top module: `phase_ref_gen`

## Requirements
- R1: While reset is asserted and after its release, before any step activity, `ref_out` is 0.
- R2: Each rising edge of `step_clk` advances the counters by exactly one step, and each rising edge of `eoc_in` restarts the phase count. Both inputs are sampled through synchronizers.
- R3: With a captured phase value p (0 to 199), `ref_out` goes high on the (p+1)-th step after the end-of-cycle marker. A value of 0 raises it on the first step.
- R4: Once high, `ref_out` stays high for exactly 100 steps and falls on the 100th step after it rose, giving a 50% duty cycle over the 200-step period.
- R5: A `phase_sel` value above 199 is treated as 199.
- R6: `phase_sel` is captured at the end-of-cycle marker. A change between markers has no effect until the next marker.
- R7: If the high-time counter expires on the same step as a new phase match, the reference is forced low. The reset wins over the set.
- R8: With `ext_sel` = 1, `ref_out` follows `ext_sync` exactly three system clocks later (two synchronizer flops and the output register).
- R9: With `ext_sel` = 0, `ext_sync` has no effect on `ref_out`.
- R10: A high window that runs past the end of a period (p above 100) continues across the next end-of-cycle marker until its 100 steps are complete.
- R11: The phase counter raises the reference at most once per period. Without a new marker, no further rising edge follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_clk | input | 1 | Excitation step clock, asynchronous level; rising edge is one step |
| eoc_in | input | 1 | End-of-cycle marker from the wavetable generator, asynchronous level |
| phase_sel | input | PH_W (8) | Phase delay in steps, 0 to 199; larger values clamp |
| ext_sync | input | 1 | External reference, asynchronous level |
| ext_sel | input | 1 | 1 selects the external reference for the output |
| ref_out | output | 1 | Demodulator sign reference |

## Verification
The embedded properties check, on every cycle, several behaviours: the captured phase stays within range and holds between markers, the high-time count stays bounded, a same-cycle set and reset leaves the output low, and the output register tracks whichever source is selected. Other behaviours show only as step sequences over whole periods, so only the bench scenarios can show them. These are the exact step on which the output rises for several phases, the 100-step high time, the clamp of large phase values, the deferred application of a phase change, the window that wraps past a marker, and the lost pulse when a phase change makes set and reset collide.

// File: rtl/prg_pkg.sv
package prg_pkg;

   // Number of bits needed to hold values 0..n-1 (at least one bit).
   function automatic int unsigned idx_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   // Output stage variant selected by the top-level parameter.
   typedef enum logic [0:0] {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("prg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/prg_edge_detect.sv
module prg_edge_detect #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] lvl_s;
   logic [WIDTH-1:0] lvl_q;

   prg_sync #(
      .WIDTH  (WIDTH),
      .STAGES (STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (level_i),
      .sync_o  (lvl_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_s;
   end

   assign rise_o = lvl_s & ~lvl_q;

   // R2: a rise pulse never lasts two cycles
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_chk
         p_single_pulse_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[b] |=> !rise_o[b]);
      end
   endgenerate

endmodule

// File: rtl/prg_phase_counter.sv
module prg_phase_counter #(
   parameter int unsigned PERIOD = 200,
   parameter int unsigned PH_W   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_p,
   input  logic            eoc_p,
   input  logic [PH_W-1:0] phase_sel,
   output logic            set_p
);

   localparam int unsigned MAX_PH = PERIOD - 1;
   localparam logic [PH_W-1:0] MAX_PH_V = PH_W'(MAX_PH);

   logic [PH_W-1:0] cnt_q;
   logic [PH_W-1:0] phase_q;
   logic            run_q;
   logic [PH_W-1:0] phase_clamped;

   // R5: out-of-range phase values are clamped to the last step
   always_comb begin
      if (phase_sel > MAX_PH_V) phase_clamped = MAX_PH_V;
      else                      phase_clamped = phase_sel;
   end

   // R6: phase captured only at the end-of-cycle marker
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= '0;
         run_q   <= 1'b0;
      end else if (eoc_p) begin
         cnt_q   <= '0;
         phase_q <= phase_clamped;
         run_q   <= 1'b1;
      end else if (step_p && run_q) begin
         if (cnt_q == phase_q) run_q <= 1'b0;      // R11: one set per period
         else                  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign set_p = step_p && run_q && !eoc_p && (cnt_q == phase_q);

   p_phase_clamp_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= MAX_PH_V);

   p_phase_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_p |=> $stable(phase_q));

   p_run_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> cnt_q <= phase_q);

   p_one_set_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      set_p |=> !run_q);

endmodule

// File: rtl/prg_half_counter.sv
module prg_half_counter #(
   parameter int unsigned HALF = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_p,
   input  logic start_p,
   output logic active_o,
   output logic rst_p
);

   localparam int unsigned HW = prg_pkg::idx_bits(HALF);
   localparam logic [HW-1:0] LAST = HW'(HALF - 1);

   logic [HW-1:0] cnt_q;
   logic          act_q;

   // A new start always restarts the window, even on the expiry step.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (start_p) begin
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (step_p && act_q) begin
         if (cnt_q == LAST) act_q <= 1'b0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rst_p    = step_p && act_q && (cnt_q == LAST);
   assign active_o = act_q;

   p_half_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> cnt_q <= LAST);

   p_start_arms_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> act_q && cnt_q == '0);

endmodule

// File: rtl/phase_ref_gen.sv
module phase_ref_gen #(
   parameter int unsigned PERIOD_STEPS = 200,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          OUT_REGISTER = 1'b1,
   parameter int unsigned PH_W         = prg_pkg::idx_bits(PERIOD_STEPS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_clk,
   input  logic            eoc_in,
   input  logic [PH_W-1:0] phase_sel,
   input  logic            ext_sync,
   input  logic            ext_sel,
   output logic            ref_out
);

   localparam int unsigned HALF_STEPS = PERIOD_STEPS / 2;
   localparam prg_pkg::out_mode_e OUT_MODE =
      OUT_REGISTER ? prg_pkg::OUT_REG : prg_pkg::OUT_COMB;

   generate
      if ((PERIOD_STEPS % 2) != 0 || PERIOD_STEPS < 4) begin : g_bad_period
         $error("phase_ref_gen: PERIOD_STEPS must be even and at least 4");
      end
      if ((1 << PH_W) < PERIOD_STEPS) begin : g_bad_phw
         $error("phase_ref_gen: PH_W too narrow for PERIOD_STEPS");
      end
   endgenerate

   logic [1:0] edges;
   logic       step_p;
   logic       eoc_p;
   logic       set_p;
   logic       rst_p;
   logic       half_act;
   logic       ext_s;
   logic       ref_q;
   logic       sel_src;

   prg_edge_detect #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i ({eoc_in, step_clk}),
      .rise_o  (edges)
   );

   assign step_p = edges[0];
   assign eoc_p  = edges[1];

   prg_phase_counter #(
      .PERIOD (PERIOD_STEPS),
      .PH_W   (PH_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_p    (step_p),
      .eoc_p     (eoc_p),
      .phase_sel (phase_sel),
      .set_p     (set_p)
   );

   prg_half_counter #(
      .HALF (HALF_STEPS)
   ) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_p   (step_p),
      .start_p  (set_p),
      .active_o (half_act),
      .rst_p    (rst_p)
   );

   prg_sync #(
      .WIDTH  (1),
      .STAGES (SYNC_STAGES)
   ) u_ext_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_sync),
      .sync_o  (ext_s)
   );

   // Set/reset reference flop, reset has priority (R7)
   always_ff @(posedge clk) begin
      if (!rst_n)     ref_q <= 1'b0;
      else if (rst_p) ref_q <= 1'b0;
      else if (set_p) ref_q <= 1'b1;
   end

   assign sel_src = ext_sel ? ext_s : ref_q;

   generate
      if (OUT_MODE == prg_pkg::OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= sel_src;
         end
         assign ref_out = out_q;

         p_ext_path_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            ext_sel |=> ref_out == $past(ext_s));

         p_int_path_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            !ext_sel |=> ref_out == $past(ref_q));
      end else begin : g_out_comb
         assign ref_out = sel_src;
      end
   endgenerate

   p_rst_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_p && rst_p) |=> !ref_q);

   p_set_arms_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_p && !rst_p) |=> ref_q && half_act);

   p_rise_needs_window_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_q) |-> half_act);

endmodule

// File: tb/phase_ref_gen_test.sv
`timescale 1ns/1ps
module phase_ref_gen_test;

   localparam int PERIOD = 200;
   localparam int HALF   = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_clk = 1'b0;
   logic       eoc_in = 1'b0;
   logic [7:0] phase_sel = '0;
   logic       ext_sync = 1'b0;
   logic       ext_sel = 1'b0;
   logic       ref_out;

   int n_checks = 0;
   int n_fail   = 0;

   // step-domain reference model
   int  m_phase  = 0;
   int  m_n      = 0;
   int  m_rem    = 0;
   bit  m_armed  = 0;
   bit  m_exp    = 0;

   always #5 clk = ~clk;

   phase_ref_gen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_clk  (step_clk),
      .eoc_in    (eoc_in),
      .phase_sel (phase_sel),
      .ext_sync  (ext_sync),
      .ext_sel   (ext_sel),
      .ref_out   (ref_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int clamp_ph(input int p);
      return (p > PERIOD - 1) ? PERIOD - 1 : p;
   endfunction

   // Advance the model by one step and return the expected level.
   function automatic bit model_step();
      bit set_now, rst_now;
      m_n++;
      set_now = m_armed && (m_n == m_phase + 1);
      if (set_now) m_armed = 0;
      rst_now = (m_rem == 1);
      if (rst_now)      m_exp = 0;
      else if (set_now) m_exp = 1;
      if (set_now)         m_rem = HALF;
      else if (m_rem > 0)  m_rem--;
      return m_exp;
   endfunction

   // One step clock period; optionally precede it with an end-of-cycle marker.
   task automatic one_step(input bit with_eoc, input string req);
      bit e;
      if (with_eoc) begin
         eoc_in  = 1'b1;
         m_phase = clamp_ph(int'(phase_sel));
         m_n     = 0;
         m_armed = 1;
      end
      tick(4);
      step_clk = 1'b1;
      tick(5);
      step_clk = 1'b0;
      eoc_in   = 1'b0;
      tick(2);
      e = model_step();
      chk(ref_out == e, req, int'(ref_out), int'(e));
      tick(1);
   endtask

   // One full excitation period; phase_sel may be changed mid-period.
   task automatic run_period(input int ph, input int mid_ph, input int mid_at,
                             input string req);
      phase_sel = 8'(ph);
      for (int s = 1; s <= PERIOD; s++) begin
         if (s == mid_at) phase_sel = 8'(mid_ph);
         one_step(s == 1, req);
      end
   endtask

   task automatic t_reset();
      tick(3);
      chk(ref_out == 1'b0, "R1 in reset", int'(ref_out), 0);
      rst_n = 1'b1;
      tick(3);
      chk(ref_out == 1'b0, "R1 after reset", int'(ref_out), 0);
      // steps without any marker never raise the output (R2 / R11)
      for (int s = 0; s < 5; s++) one_step(1'b0, "R11 no marker");
   endtask

   task automatic t_phase_zero();
      run_period(0, 0, 0, "R3 phase 0");
      run_period(0, 0, 0, "R4 phase 0 duty");
   endtask

   task automatic t_phase_mid();
      run_period(37, 37, 0, "R3 phase 37");
      run_period(37, 37, 0, "R4 phase 37 duty");
   endtask

   task automatic t_phase_wrap();
      run_period(150, 150, 0, "R10 phase 150");
      run_period(150, 150, 0, "R10 wrap window");
   endtask

   task automatic t_phase_max();
      run_period(199, 199, 0, "R3 phase 199");
      run_period(255, 255, 0, "R5 clamp 255");
      run_period(230, 230, 0, "R5 clamp 230");
   endtask

   task automatic t_deferred();
      run_period(20, 120, 10, "R6 deferred change");
      run_period(120, 120, 0, "R6 applied next");
   endtask

   task automatic t_collision();
      run_period(150, 150, 0, "R7 setup");
      run_period(50, 50, 0, "R7 reset wins");
      run_period(50, 50, 0, "R7 recovery");
   endtask

   task automatic t_ext();
      bit held;
      held = ref_out;
      // R9: external input ignored while not selected
      for (int k = 0; k < 4; k++) begin
         ext_sync = ~ext_sync;
         tick(4);
         chk(ref_out == held, "R9 ext ignored", int'(ref_out), int'(held));
      end
      ext_sync = 1'b0;
      ext_sel  = 1'b1;
      tick(4);
      chk(ref_out == 1'b0, "R8 ext low", int'(ref_out), 0);
      ext_sync = 1'b1;
      tick(2);
      chk(ref_out == 1'b0, "R8 latency not yet", int'(ref_out), 0);
      tick(1);
      chk(ref_out == 1'b1, "R8 latency 3", int'(ref_out), 1);
      ext_sync = 1'b0;
      tick(2);
      chk(ref_out == 1'b1, "R8 fall not yet", int'(ref_out), 1);
      tick(1);
      chk(ref_out == 1'b0, "R8 fall 3", int'(ref_out), 0);
      ext_sel = 1'b0;
      tick(3);
      chk(ref_out == held, "R9 back to internal", int'(ref_out), int'(held));
      run_period(90, 90, 0, "R9 internal resumes");
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_phase_zero();
      t_phase_mid();
      t_phase_wrap();
      t_phase_max();
      t_deferred();
      t_collision();
      t_ext();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule